// File: doc/BRIEF.md
# Flash Status and Write-Protection Gate

This block holds the status byte of a serial NOR flash and decides which modifying commands the device is allowed to carry out. A command decoder that sits in front of it supplies one-cycle strobes. These cover arming and disarming the write latch, writing the status byte, programming a page, erasing a sector, erasing the whole array and reading the status. Alongside the strobes come a byte address, the data for a status write and an active-low write-protect pin. Accepted program and erase operations go to an abstract array engine as a start pulse carrying an opcode and an address. The engine signals that it has finished with a done strobe.

Before a modifying command is accepted, four conditions are checked. The write latch must be armed. The target must lie outside the region selected by the three guard bits. A bulk erase needs all guard bits at zero. A status write is refused while the lock bit is set and the protect pin is held low. While an operation runs, the busy bit stays set and every modifying strobe is ignored. Status reads are served at any time.

Top module: `flash_status_guard`

## Requirements
- R1: After reset the status byte is 0x00 and no engine start is issued.
- R2: The status byte holds busy in bit 0, the write latch in bit 1, the guard code in bits 4:2, zeros in bits 6:5 and the lock bit in bit 7. A read strobe produces rd_valid one cycle later, with rd_data equal to the status byte present in the cycle of the strobe. This also works while busy.
- R3: When not busy, an arm strobe sets the write latch and a disarm strobe clears it.
- R4: While the write latch is 0, status-write, program, sector-erase and bulk-erase strobes are rejected. No engine start is issued and the status byte does not change.
- R5: An accepted program, sector erase or bulk erase produces a one-cycle eng_start in the next cycle. The accompanying eng_op is 1 for program, 2 for sector erase and 3 for bulk erase, and eng_addr carries the command address. Busy is 1 from that cycle on. In the cycle after eng_done, busy and the write latch both read 0.
- R6: A guard code g from 1 to 5 protects every address at or above 2^ADDR_W − 2^(ADDR_W−6+g). Codes 6 and 7 protect the whole array. A program is rejected if its address is protected. A sector erase is rejected if any address of its sector is protected. A sector is defined by the top SECT_BITS address bits.
- R7: A bulk erase is accepted only while the guard code is 0.
- R8: An accepted status write keeps busy at 1 for exactly WSR_CYCLES cycles and issues no engine start. It then loads the guard from wr_data[4:2] and the lock bit from wr_data[7], and clears busy and the write latch, all in the same cycle.
- R9: While the lock bit is 1 and wp_n is 0, a status write is rejected and the write latch stays set.
- R10: While busy is 1, all modifying strobes are ignored. eng_done has no effect when no engine operation is running.
- R11: If several modifying strobes arrive in one cycle, only one is considered. Disarm wins over arm, arm over status write, then program, then sector erase, then bulk erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_arm | input | 1 | Arm the write latch |
| cmd_disarm | input | 1 | Disarm the write latch |
| cmd_stwr | input | 1 | Write status byte |
| cmd_prog | input | 1 | Page program |
| cmd_sect | input | 1 | Sector erase |
| cmd_bulk | input | 1 | Bulk erase |
| cmd_stat | input | 1 | Read status byte |
| addr | input | ADDR_W | Target byte address |
| wr_data | input | 8 | Status write data |
| wp_n | input | 1 | Write-protect pin, active low |
| eng_done | input | 1 | Array engine finished |
| eng_start | output | 1 | Start pulse to array engine |
| eng_op | output | 2 | Engine opcode (1 program, 2 sector, 3 bulk) |
| eng_addr | output | ADDR_W | Engine target address |
| status | output | 8 | Live status byte |
| rd_valid | output | 1 | Status read data valid |
| rd_data | output | 8 | Status byte captured by a read |

## Verification
Two pairs of events can coincide in one cycle. The first is an engine done strobe arriving together with a status read and an arm strobe. The bench provokes it on purpose: the read must return the byte with busy still set, and the arm must be lost, leaving the write latch at 0 after completion. The second is a disarm colliding with an arm, or a status write colliding with a program. Here the priority order decides which one takes effect. A behavioural model in the bench follows every clock and flags any divergence in the status byte, the read data or the engine start.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PROG = 2'd1,
        OP_SECT = 2'd2,
        OP_BULK = 2'd3
    } eng_op_e;

    typedef enum logic [1:0] {
        BUSY_IDLE = 2'd0,
        BUSY_STWR = 2'd1,
        BUSY_ENG  = 2'd2
    } busy_e;
endpackage

// File: rtl/fsg_region.sv
module fsg_region #(
    parameter int ADDR_W    = 19,
    parameter int SECT_BITS = 3
) (
    input  logic [2:0]        guard,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_prog,
    output logic              hit_sect
);
    localparam logic [ADDR_W-1:0] ALL_ONES  = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] SECT_LOW  = ALL_ONES >> SECT_BITS;

    logic [ADDR_W-1:0] top_mask;
    logic [ADDR_W-1:0] sect_last;

    // Upper region mask: guard g keeps the top (6-g) address bits fixed at one.
    always_comb begin
        top_mask  = ~(ALL_ONES >> (6 - int'(guard)));
        sect_last = addr | SECT_LOW;
        if (guard == 3'd0) begin
            hit_prog = 1'b0;
            hit_sect = 1'b0;
        end else if (guard >= 3'd6) begin
            hit_prog = 1'b1;
            hit_sect = 1'b1;
        end else begin
            hit_prog = (addr & top_mask) == top_mask;
            hit_sect = (sect_last & top_mask) == top_mask;
        end
    end
endmodule

// File: rtl/fsg_gate.sv
module fsg_gate (
    input  logic       busy,
    input  logic       armed,
    input  logic       lock,
    input  logic       wp_n,
    input  logic [2:0] guard,
    input  logic       hit_prog,
    input  logic       hit_sect,
    input  logic       cmd_arm,
    input  logic       cmd_disarm,
    input  logic       cmd_stwr,
    input  logic       cmd_prog,
    input  logic       cmd_sect,
    input  logic       cmd_bulk,
    output logic       take_arm,
    output logic       take_disarm,
    output logic       take_stwr,
    output logic       take_prog,
    output logic       take_sect,
    output logic       take_bulk
);
    logic hw_locked;

    always_comb begin
        hw_locked   = lock && !wp_n;
        take_arm    = 1'b0;
        take_disarm = 1'b0;
        take_stwr   = 1'b0;
        take_prog   = 1'b0;
        take_sect   = 1'b0;
        take_bulk   = 1'b0;
        if (!busy) begin
            if (cmd_disarm)      take_disarm = 1'b1;
            else if (cmd_arm)    take_arm    = 1'b1;
            else if (cmd_stwr)   take_stwr   = armed && !hw_locked;
            else if (cmd_prog)   take_prog   = armed && !hit_prog;
            else if (cmd_sect)   take_sect   = armed && !hit_sect;
            else if (cmd_bulk)   take_bulk   = armed && (guard == 3'd0);
        end
    end
endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard #(
    parameter int ADDR_W     = 19,
    parameter int SECT_BITS  = 3,
    parameter int WSR_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_arm,
    input  logic              cmd_disarm,
    input  logic              cmd_stwr,
    input  logic              cmd_prog,
    input  logic              cmd_sect,
    input  logic              cmd_bulk,
    input  logic              cmd_stat,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    input  logic              wp_n,
    input  logic              eng_done,
    output logic              eng_start,
    output logic [1:0]        eng_op,
    output logic [ADDR_W-1:0] eng_addr,
    output logic [7:0]        status,
    output logic              rd_valid,
    output logic [7:0]        rd_data
);
    import fsg_pkg::*;

    localparam int CNT_W = (WSR_CYCLES > 1) ? $clog2(WSR_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WSR_CYCLES - 1);

    typedef struct packed {
        busy_e             busy;
        logic              armed;
        logic [2:0]        guard;
        logic              lock;
        logic [CNT_W-1:0]  cnt;
        logic [2:0]        guard_new;
        logic              lock_new;
        logic              start;
        eng_op_e           op;
        logic [ADDR_W-1:0] eaddr;
        logic              rdv;
        logic [7:0]        rdd;
    } state_t;

    state_t st_d, st_q;

    logic hit_prog, hit_sect;
    logic take_arm, take_disarm, take_stwr, take_prog, take_sect, take_bulk;
    logic busy_bit;
    logic [7:0] stat_byte;
    logic unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[6:5], wr_data[1:0]};
    assign busy_bit  = (st_q.busy != BUSY_IDLE);
    assign stat_byte = {st_q.lock, 2'b00, st_q.guard, st_q.armed, busy_bit};

    fsg_region #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS)) u_region (
        .guard    (st_q.guard),
        .addr     (addr),
        .hit_prog (hit_prog),
        .hit_sect (hit_sect)
    );

    fsg_gate u_gate (
        .busy        (busy_bit),
        .armed       (st_q.armed),
        .lock        (st_q.lock),
        .wp_n        (wp_n),
        .guard       (st_q.guard),
        .hit_prog    (hit_prog),
        .hit_sect    (hit_sect),
        .cmd_arm     (cmd_arm),
        .cmd_disarm  (cmd_disarm),
        .cmd_stwr    (cmd_stwr),
        .cmd_prog    (cmd_prog),
        .cmd_sect    (cmd_sect),
        .cmd_bulk    (cmd_bulk),
        .take_arm    (take_arm),
        .take_disarm (take_disarm),
        .take_stwr   (take_stwr),
        .take_prog   (take_prog),
        .take_sect   (take_sect),
        .take_bulk   (take_bulk)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.op    = OP_NONE;
        st_d.rdv   = cmd_stat;
        if (cmd_stat) st_d.rdd = stat_byte;

        unique case (st_q.busy)
            BUSY_STWR: begin
                if (st_q.cnt == '0) begin
                    st_d.guard = st_q.guard_new;
                    st_d.lock  = st_q.lock_new;
                    st_d.armed = 1'b0;
                    st_d.busy  = BUSY_IDLE;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            BUSY_ENG: begin
                if (eng_done) begin
                    st_d.armed = 1'b0;
                    st_d.busy  = BUSY_IDLE;
                end
            end
            default: begin
                if (take_disarm) st_d.armed = 1'b0;
                if (take_arm)    st_d.armed = 1'b1;
                if (take_stwr) begin
                    st_d.busy      = BUSY_STWR;
                    st_d.cnt       = CNT_LOAD;
                    st_d.guard_new = wr_data[4:2];
                    st_d.lock_new  = wr_data[7];
                end
                if (take_prog || take_sect || take_bulk) begin
                    st_d.busy  = BUSY_ENG;
                    st_d.start = 1'b1;
                    st_d.eaddr = addr;
                    st_d.op    = take_prog ? OP_PROG : (take_sect ? OP_SECT : OP_BULK);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign eng_start = st_q.start;
    assign eng_op    = st_q.op;
    assign eng_addr  = st_q.eaddr;
    assign status    = stat_byte;
    assign rd_valid  = st_q.rdv;
    assign rd_data   = st_q.rdd;

    assert_one_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_arm, take_disarm, take_stwr, take_prog, take_sect, take_bulk}));

    assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    assert_start_needs_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> $past(st_q.armed));

    assert_busy_keeps_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_bit |-> st_q.armed);

    assert_guard_only_stwr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.guard) |-> $past(st_q.busy == BUSY_STWR));

    assert_bulk_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && eng_op == 2'd3) |-> ($past(st_q.guard) == 3'd0));

    assert_hw_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_stwr) && $past(st_q.lock) && !$past(wp_n) && !$past(busy_bit)) |-> !busy_bit);

    assert_read_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(cmd_stat));
endmodule

// File: tb/tb_flash_status_guard.sv
module tb_flash_status_guard;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 19;
    localparam int SB   = 3;
    localparam int WSRC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_arm = 0, cmd_disarm = 0, cmd_stwr = 0, cmd_prog = 0;
    logic cmd_sect = 0, cmd_bulk = 0, cmd_stat = 0;
    logic [AW-1:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic wp_n = 1'b1;
    logic eng_done = 1'b0;
    logic eng_start;
    logic [1:0] eng_op;
    logic [AW-1:0] eng_addr;
    logic [7:0] status;
    logic rd_valid;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural reference state
    int       m_busy = 0;   // 0 idle, 1 status write, 2 engine
    bit       m_armed = 0;
    bit [2:0] m_guard = 0;
    bit       m_lock = 0;
    int       m_cnt = 0;
    bit [7:0] m_pend = 0;
    bit       m_start = 0;
    int       m_op = 0;
    int       m_ea = 0;
    bit       m_rdv = 0;
    bit [7:0] m_rdd = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_status_guard #(.ADDR_W(AW), .SECT_BITS(SB), .WSR_CYCLES(WSRC)) dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_arm(cmd_arm), .cmd_disarm(cmd_disarm), .cmd_stwr(cmd_stwr),
        .cmd_prog(cmd_prog), .cmd_sect(cmd_sect), .cmd_bulk(cmd_bulk),
        .cmd_stat(cmd_stat), .addr(addr), .wr_data(wr_data), .wp_n(wp_n),
        .eng_done(eng_done), .eng_start(eng_start), .eng_op(eng_op),
        .eng_addr(eng_addr), .status(status), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic bit [7:0] m_byte();
        return {m_lock, 2'b00, m_guard, m_armed, (m_busy != 0)};
    endfunction

    function automatic bit prot(int a, bit sector);
        longint size, first, probe, sect_sz;
        if (m_guard == 0) return 0;
        if (m_guard >= 6) return 1;
        size    = longint'(1) << (AW - 6 + m_guard);
        first   = (longint'(1) << AW) - size;
        sect_sz = longint'(1) << (AW - SB);
        probe   = sector ? ((a / sect_sz) * sect_sz + sect_sz - 1) : a;
        return probe >= first;
    endfunction

    task automatic model_step();
        bit [7:0] now = m_byte();
        m_rdv = cmd_stat;
        if (cmd_stat) m_rdd = now;
        m_start = 0;
        if (m_busy == 1) begin
            if (m_cnt == 0) begin
                m_guard = m_pend[4:2]; m_lock = m_pend[7]; m_armed = 0; m_busy = 0;
            end else m_cnt--;
        end else if (m_busy == 2) begin
            if (eng_done) begin m_busy = 0; m_armed = 0; end
        end else begin
            if (cmd_disarm) m_armed = 0;
            else if (cmd_arm) m_armed = 1;
            else if (cmd_stwr) begin
                if (m_armed && !(m_lock && !wp_n)) begin
                    m_busy = 1; m_cnt = WSRC - 1; m_pend = wr_data;
                end
            end else if (cmd_prog) begin
                if (m_armed && !prot(int'(addr), 0)) begin
                    m_busy = 2; m_start = 1; m_op = 1; m_ea = int'(addr);
                end
            end else if (cmd_sect) begin
                if (m_armed && !prot(int'(addr), 1)) begin
                    m_busy = 2; m_start = 1; m_op = 2; m_ea = int'(addr);
                end
            end else if (cmd_bulk) begin
                if (m_armed && m_guard == 0) begin
                    m_busy = 2; m_start = 1; m_op = 3; m_ea = int'(addr);
                end
            end
        end
    endtask

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic compare();
        chk(status == m_byte(), "R2 status byte", int'(status), int'(m_byte()));
        chk(rd_valid == m_rdv, "R2 rd_valid", int'(rd_valid), int'(m_rdv));
        if (m_rdv) chk(rd_data == m_rdd, "R2 rd_data", int'(rd_data), int'(m_rdd));
        chk(eng_start == m_start, "R5 eng_start", int'(eng_start), int'(m_start));
        if (m_start) begin
            chk(int'(eng_op) == m_op, "R5 eng_op", int'(eng_op), m_op);
            chk(int'(eng_addr) == m_ea, "R5 eng_addr", int'(eng_addr), m_ea);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst_n) model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20 && status[0]; i++) tick();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<5000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(status == 8'h00, "R1 reset status", int'(status), 0);
        chk(eng_start == 1'b0, "R1 reset start", int'(eng_start), 0);

        // R4: program without the latch
        addr = 19'h00100; cmd_prog = 1; tick(); cmd_prog = 0;
        chk(eng_start == 0 && status == 8'h00, "R4 unarmed program", int'(status), 0);

        // R3: arm
        cmd_arm = 1; tick(); cmd_arm = 0;
        chk(status == 8'h02, "R3 arm", int'(status), 8'h02);

        // R2: read
        cmd_stat = 1; tick(); cmd_stat = 0;
        chk(rd_valid && rd_data == 8'h02, "R2 read byte", int'(rd_data), 8'h02);

        // R5: program accepted
        addr = 19'h00100; cmd_prog = 1; tick(); cmd_prog = 0;
        chk(eng_start && eng_op == 2'd1, "R5 program start", int'(eng_op), 1);
        chk(status == 8'h03, "R5 busy set", int'(status), 8'h03);
        cmd_disarm = 1; tick(); cmd_disarm = 0;
        chk(status == 8'h03, "R10 disarm ignored while busy", int'(status), 8'h03);
        eng_done = 1; tick(); eng_done = 0;
        chk(status == 8'h00, "R5 completion clears", int'(status), 0);

        // R8: status write guard=5 lock=1
        cmd_arm = 1; tick(); cmd_arm = 0;
        wr_data = 8'h94; cmd_stwr = 1; tick(); cmd_stwr = 0;
        chk(eng_start == 0, "R8 no engine start", int'(eng_start), 0);
        n = 0;
        for (int i = 0; i < 20 && status[0]; i++) begin n++; tick(); end
        chk(n == WSRC, "R8 busy length", n, WSRC);
        chk(status == 8'h94, "R8 committed byte", int'(status), 8'h94);

        // R6: upper half protected
        cmd_arm = 1; tick(); cmd_arm = 0;
        addr = 19'h7FFFF; cmd_prog = 1; tick(); cmd_prog = 0;
        chk(eng_start == 0 && status == 8'h96, "R6 protected program", int'(status), 8'h96);
        addr = 19'h3FFFF; cmd_prog = 1; tick(); cmd_prog = 0;
        chk(eng_start == 1, "R6 unprotected program", int'(eng_start), 1);
        eng_done = 1; tick(); eng_done = 0;
        cmd_arm = 1; tick(); cmd_arm = 0;
        addr = 19'h40000; cmd_sect = 1; tick(); cmd_sect = 0;
        chk(eng_start == 0 && status == 8'h96, "R6 protected sector", int'(status), 8'h96);
        cmd_bulk = 1; tick(); cmd_bulk = 0;
        chk(eng_start == 0 && status == 8'h96, "R7 bulk with guard", int'(status), 8'h96);
        cmd_disarm = 1; tick(); cmd_disarm = 0;
        chk(status == 8'h94, "R3 disarm", int'(status), 8'h94);

        // R9: hardware lock
        wp_n = 0;
        cmd_arm = 1; tick(); cmd_arm = 0;
        wr_data = 8'h00; cmd_stwr = 1; tick(); cmd_stwr = 0;
        chk(status == 8'h96, "R9 locked write rejected", int'(status), 8'h96);
        wp_n = 1;
        wr_data = 8'h04; cmd_stwr = 1; tick(); cmd_stwr = 0;
        wait_idle();
        chk(status == 8'h04, "R9 unlocked write", int'(status), 8'h04);

        // R6: guard 1, sector 7 overlaps top 1/32
        cmd_arm = 1; tick(); cmd_arm = 0;
        addr = 19'h70000; cmd_sect = 1; tick(); cmd_sect = 0;
        chk(eng_start == 0 && status == 8'h06, "R6 overlapping sector", int'(status), 8'h06);
        addr = 19'h7BFFF; cmd_prog = 1; tick(); cmd_prog = 0;
        chk(eng_start == 1, "R6 program below boundary", int'(eng_start), 1);
        tick();
        // done, read and arm together
        eng_done = 1; cmd_stat = 1; cmd_arm = 1; tick();
        eng_done = 0; cmd_stat = 0; cmd_arm = 0;
        chk(rd_data == 8'h07, "R2 read at completion", int'(rd_data), 8'h07);
        chk(status == 8'h04, "R10 arm lost while busy", int'(status), 8'h04);

        // R7: clear guard then bulk erase
        cmd_arm = 1; tick(); cmd_arm = 0;
        wr_data = 8'h00; cmd_stwr = 1; tick(); cmd_stwr = 0;
        wait_idle();
        cmd_arm = 1; tick(); cmd_arm = 0;
        addr = 19'h00000; cmd_bulk = 1; tick(); cmd_bulk = 0;
        chk(eng_start && eng_op == 2'd3, "R7 bulk accepted", int'(eng_op), 3);
        eng_done = 1; tick(); eng_done = 0;

        // R11: priority
        cmd_arm = 1; cmd_disarm = 1; tick(); cmd_arm = 0; cmd_disarm = 0;
        chk(status == 8'h00, "R11 disarm beats arm", int'(status), 0);
        cmd_arm = 1; tick(); cmd_arm = 0;
        wr_data = 8'h08; addr = 19'h00010; cmd_stwr = 1; cmd_prog = 1; tick();
        cmd_stwr = 0; cmd_prog = 0;
        chk(eng_start == 0 && status == 8'h03, "R11 status write beats program", int'(status), 8'h03);
        wait_idle();
        chk(status == 8'h08, "R11 status write committed", int'(status), 8'h08);

        // R10: stray done while idle
        eng_done = 1; tick(); eng_done = 0;
        chk(status == 8'h08 && eng_start == 0, "R10 idle done ignored", int'(status), 8'h08);
        repeat (3) tick();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule